// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Pair

This block connects two processor cores through a pair of word-wide mailbox queues, one for each direction. Every core sees the same small register window: a transmit slot, a receive slot and a status word. The block wires these slots crosswise. Core 0's transmit slot feeds the queue that core 1 drains through its receive slot, and the opposite holds for core 1's transmit slot.

The block has two register ports. Each port tags its access with the ID of the core that issues it, and that ID decides which queue ends the access reaches. Each core gets one interrupt line. The line is raised while the core has mail waiting or while one of its sticky error flags is set. Errors come from a write into a full queue or a read from an empty one. Both cores and the block share one clock. Reads are single-cycle: read data is driven in the same cycle as the request, and queue and flag state change at the following clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty, all error flags are clear, both `irq_o` bits are low, and a status read returns 0x2 (only the room bit is set).
- R2: A word written to the transmit slot by core N can be read from core (1-N)'s receive slot. Words come out in the order they were written. The core ID on each port alone selects the queue, whichever port carries the access.
- R3: Each queue holds DEPTH (8) words. A write to a full queue is discarded. This holds even when the other core pops that queue in the same cycle, because fullness is judged on the state before the clock edge.
- R4: A write to a full transmit queue sets that core's overflow flag (status bit 2). The flag stays set until it is cleared.
- R5: A read of an empty receive queue returns zero, sets that core's underflow flag (status bit 3), and leaves the queue unchanged.
- R6: A write of any data to the status slot clears both error flags of the writing core.
- R7: `irq_o[N]` is the OR of core N's mail-available bit (status bit 0), overflow flag and underflow flag.
- R8: When the two ports carry different core IDs, both accesses in a cycle complete independently.
- R9: When both ports request with the same core ID, port A is served. Port B's access has no effect and its read data is zero.
- R10: The slot offsets are: 0 transmit (write only), 1 receive (read only), 2 status. Status bit 1 is set when the core's transmit queue is not full. Any other offset, or the wrong direction on a slot, reads zero and changes nothing.
- R11: Read data is valid in the cycle the read is requested. The pop or flag change it causes is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_req_i | input | 1 | Port A access request |
| a_we_i | input | 1 | Port A write (1) or read (0) |
| a_core_i | input | 1 | Core ID issuing the port A access |
| a_addr_i | input | 2 | Port A slot offset |
| a_wdata_i | input | DW | Port A write data |
| a_rdata_o | output | DW | Port A read data, same cycle |
| b_req_i | input | 1 | Port B access request |
| b_we_i | input | 1 | Port B write (1) or read (0) |
| b_core_i | input | 1 | Core ID issuing the port B access |
| b_addr_i | input | 2 | Port B slot offset |
| b_wdata_i | input | DW | Port B write data |
| b_rdata_o | output | DW | Port B read data, same cycle |
| irq_o | output | 2 | Interrupt per core, bit N for core N |

## Verification
A corrupted queue pointer or count shows up within a cycle as a wrong status word on the next status read, or as a wrong word on the next receive read. A wrongly decoded core ID routes mail to the writer's own receive slot. That shows up at the first read from the intended receiver. A lost or stuck error flag becomes visible on `irq_o` in the cycle after the access that should have changed it, so the bench compares both read-data buses and the interrupt pair against a queue model every cycle.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

  typedef enum logic [1:0] {
    SLOT_TX   = 2'd0,
    SLOT_RX   = 2'd1,
    SLOT_STAT = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  localparam int unsigned ST_AVAIL = 0;
  localparam int unsigned ST_ROOM  = 1;
  localparam int unsigned ST_OVF   = 2;
  localparam int unsigned ST_UDF   = 3;

  typedef struct packed {
    logic tx_wr;
    logic rx_rd;
    logic st_rd;
    logic st_wr;
  } port_op_t;

endpackage

// File: rtl/ipc_mailbox_fifo.sv
module ipc_mailbox_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,   // caller gates with !full_o
  input  logic          pop_i,    // caller gates with !empty_o
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= bump(wptr_q);
      if (pop_i)  rptr_q <= bump(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

endmodule

// File: rtl/ipc_mailbox_port_dec.sv
module ipc_mailbox_port_dec
  import ipc_mailbox_pkg::*;
(
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  output port_op_t   op_o
);

  slot_e slot;
  assign slot = slot_e'(addr_i);

  always_comb begin
    op_o       = '0;
    op_o.tx_wr = req_i &  we_i & (slot == SLOT_TX);
    op_o.rx_rd = req_i & ~we_i & (slot == SLOT_RX);
    op_o.st_rd = req_i & ~we_i & (slot == SLOT_STAT);
    op_o.st_wr = req_i &  we_i & (slot == SLOT_STAT);
  end

endmodule

// File: rtl/ipc_mailbox_err_flags.sv
module ipc_mailbox_err_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_wr_i,
  input  logic tx_full_i,
  input  logic rx_rd_i,
  input  logic rx_empty_i,
  input  logic st_wr_i,
  output logic ovf_o,
  output logic udf_o
);

  // one access per core per cycle, so set and clear never meet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      if (tx_wr_i && tx_full_i) ovf_o <= 1'b1;
      else if (st_wr_i)         ovf_o <= 1'b0;
      if (rx_rd_i && rx_empty_i) udf_o <= 1'b1;
      else if (st_wr_i)          udf_o <= 1'b0;
    end
  end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_req_i,
  input  logic          a_we_i,
  input  logic          a_core_i,
  input  logic [1:0]    a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_req_i,
  input  logic          b_we_i,
  input  logic          b_core_i,
  input  logic [1:0]    b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  output logic [1:0]    irq_o
);

  localparam int unsigned NC = 2;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [NC-1:0]          p_live, p_we, p_core;
  logic [NC-1:0][1:0]     p_addr;
  logic [NC-1:0][DW-1:0]  p_wdata, p_rdata;
  port_op_t               p_op [NC];

  logic [NC-1:0]          core_tx_wr, core_rx_rd, core_st_wr;
  logic [NC-1:0][DW-1:0]  core_wd;
  logic [NC-1:0]          fifo_full, fifo_empty;
  logic [NC-1:0][DW-1:0]  fifo_head;
  logic [NC-1:0][CW-1:0]  fifo_cnt;
  logic [NC-1:0]          err_ovf, err_udf;

  // port B yields when both ports claim the same core
  assign p_live[0]  = a_req_i;
  assign p_live[1]  = b_req_i & ~(a_req_i & (a_core_i == b_core_i));
  assign p_we       = {b_we_i, a_we_i};
  assign p_core     = {b_core_i, a_core_i};
  assign p_addr     = {b_addr_i, a_addr_i};
  assign p_wdata    = {b_wdata_i, a_wdata_i};
  assign a_rdata_o  = p_rdata[0];
  assign b_rdata_o  = p_rdata[1];

  for (genvar p = 0; p < NC; p++) begin : g_port
    logic rx_sel;
    assign rx_sel = ~p_core[p];

    ipc_mailbox_port_dec u_dec (
      .req_i  (p_live[p]),
      .we_i   (p_we[p]),
      .addr_i (p_addr[p]),
      .op_o   (p_op[p])
    );

    always_comb begin
      p_rdata[p] = '0;
      if (p_op[p].rx_rd && !fifo_empty[rx_sel]) begin
        p_rdata[p] = fifo_head[rx_sel];
      end else if (p_op[p].st_rd) begin
        p_rdata[p][ST_AVAIL] = ~fifo_empty[rx_sel];
        p_rdata[p][ST_ROOM]  = ~fifo_full[p_core[p]];
        p_rdata[p][ST_OVF]   = err_ovf[p_core[p]];
        p_rdata[p][ST_UDF]   = err_udf[p_core[p]];
      end
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_core
    always_comb begin
      core_tx_wr[c] = 1'b0;
      core_rx_rd[c] = 1'b0;
      core_st_wr[c] = 1'b0;
      core_wd[c]    = '0;
      for (int p = 0; p < NC; p++) begin
        if (p_live[p] && (p_core[p] == 1'(c))) begin
          core_tx_wr[c] = core_tx_wr[c] | p_op[p].tx_wr;
          core_rx_rd[c] = core_rx_rd[c] | p_op[p].rx_rd;
          core_st_wr[c] = core_st_wr[c] | p_op[p].st_wr;
          core_wd[c]    = p_wdata[p];
        end
      end
    end

    // queue c carries core c -> core (NC-1-c)
    ipc_mailbox_fifo #(
      .DW    (DW),
      .DEPTH (DEPTH)
    ) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (core_tx_wr[c] & ~fifo_full[c]),
      .pop_i   (core_rx_rd[NC-1-c] & ~fifo_empty[c]),
      .wdata_i (core_wd[c]),
      .head_o  (fifo_head[c]),
      .full_o  (fifo_full[c]),
      .empty_o (fifo_empty[c]),
      .count_o (fifo_cnt[c])
    );

    ipc_mailbox_err_flags u_err (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tx_wr_i    (core_tx_wr[c]),
      .tx_full_i  (fifo_full[c]),
      .rx_rd_i    (core_rx_rd[c]),
      .rx_empty_i (fifo_empty[NC-1-c]),
      .st_wr_i    (core_st_wr[c]),
      .ovf_o      (err_ovf[c]),
      .udf_o      (err_udf[c])
    );

    assign irq_o[c] = ~fifo_empty[NC-1-c] | err_ovf[c] | err_udf[c];
  end

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          irq_o,
  input logic [1:0][CW-1:0]  fifo_cnt,
  input logic [1:0]          fifo_full,
  input logic [1:0]          fifo_empty,
  input logic [1:0]          core_tx_wr,
  input logic [1:0]          core_rx_rd,
  input logic [1:0]          core_st_wr,
  input logic [1:0]          err_ovf,
  input logic [1:0]          err_udf
);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_cnt[c] <= CW'(DEPTH));

    p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fifo_full[c] && core_tx_wr[c] && !core_rx_rd[1-c]) |=> $stable(fifo_cnt[c]));

    p_ovf_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_ovf[c]) |-> $past(fifo_full[c] && core_tx_wr[c]));

    p_udf_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_udf[c]) |-> $past(fifo_empty[1-c] && core_rx_rd[c]));

    p_udf_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fifo_empty[1-c] && core_rx_rd[c] && !core_tx_wr[1-c]) |=> fifo_empty[1-c]);

    p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_st_wr[c] |=> (!err_ovf[c] && !err_udf[c]));

    p_irq_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_ovf[c] || err_udf[c]) |-> irq_o[c]);

    p_single_access_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({core_tx_wr[c], core_rx_rd[c], core_st_wr[c]}));
  end

endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_o      (irq_o),
  .fifo_cnt   (fifo_cnt),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .core_tx_wr (core_tx_wr),
  .core_rx_rd (core_rx_rd),
  .core_st_wr (core_st_wr),
  .err_ovf    (err_ovf),
  .err_udf    (err_udf)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;

  localparam int DW    = 32;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          a_req = 0, a_we = 0, a_core = 0;
  logic [1:0]    a_addr = 0;
  logic [DW-1:0] a_wdata = 0;
  logic [DW-1:0] a_rdata;
  logic          b_req = 0, b_we = 0, b_core = 0;
  logic [1:0]    b_addr = 0;
  logic [DW-1:0] b_wdata = 0;
  logic [DW-1:0] b_rdata;
  logic [1:0]    irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  ipc_mailbox #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_req_i(a_req), .a_we_i(a_we), .a_core_i(a_core), .a_addr_i(a_addr),
    .a_wdata_i(a_wdata), .a_rdata_o(a_rdata),
    .b_req_i(b_req), .b_we_i(b_we), .b_core_i(b_core), .b_addr_i(b_addr),
    .b_wdata_i(b_wdata), .b_rdata_o(b_rdata),
    .irq_o(irq)
  );

  // model: q0 carries core0->core1, q1 carries core1->core0
  logic [DW-1:0] q0[$];
  logic [DW-1:0] q1[$];
  bit m_ovf[2];
  bit m_udf[2];

  function automatic int qsize(int f);
    return (f == 0) ? q0.size() : q1.size();
  endfunction

  function automatic logic [DW-1:0] qfront(int f);
    return (f == 0) ? q0[0] : q1[0];
  endfunction

  function automatic logic [DW-1:0] model_rd(int c, logic we, logic [1:0] addr);
    logic [DW-1:0] r = '0;
    if (!we && addr == 2'd1 && qsize(1 - c) > 0) r = qfront(1 - c);
    if (!we && addr == 2'd2)
      r = {28'd0, m_udf[c], m_ovf[c], qsize(c) < DEPTH, qsize(1 - c) > 0};
    return r;
  endfunction

  task automatic model_apply(int c, logic we, logic [1:0] addr, logic [DW-1:0] wd,
                             bit full_c, bit empty_rx);
    if (we && addr == 2'd0) begin
      if (full_c) m_ovf[c] = 1;
      else if (c == 0) q0.push_back(wd);
      else q1.push_back(wd);
    end else if (we && addr == 2'd2) begin
      m_ovf[c] = 0;
      m_udf[c] = 0;
    end else if (!we && addr == 2'd1) begin
      if (empty_rx) m_udf[c] = 1;
      else if (c == 0) void'(q1.pop_front());
      else void'(q0.pop_front());
    end
  endtask

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, compare mid-low phase, update model at posedge
  task automatic cyc(string tag,
                     logic ar, logic aw, logic ac, logic [1:0] aa, logic [DW-1:0] ad,
                     logic br, logic bw, logic bc, logic [1:0] ba, logic [DW-1:0] bd);
    bit b_live;
    bit fl[2];
    bit em[2];
    logic [DW-1:0] ea, eb;
    a_req = ar; a_we = aw; a_core = ac; a_addr = aa; a_wdata = ad;
    b_req = br; b_we = bw; b_core = bc; b_addr = ba; b_wdata = bd;
    b_live = br && !(ar && ac == bc);
    #5;
    ea = ar ? model_rd(int'(ac), aw, aa) : '0;
    eb = b_live ? model_rd(int'(bc), bw, ba) : '0;
    check(tag, "a_rdata", a_rdata, ea);
    check(tag, "b_rdata", b_rdata, eb);
    check("R7", "irq", {30'd0, irq},
          {30'd0, (qsize(0) > 0) | m_ovf[1] | m_udf[1], (qsize(1) > 0) | m_ovf[0] | m_udf[0]});
    for (int f = 0; f < 2; f++) begin
      fl[f] = qsize(f) >= DEPTH;
      em[f] = qsize(f) == 0;
    end
    @(posedge clk);
    if (ar) model_apply(int'(ac), aw, aa, ad, fl[ac], em[1 - ac]);
    if (b_live) model_apply(int'(bc), bw, ba, bd, fl[bc], em[1 - bc]);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 2'd0, '0, 0, 0, 0, 2'd0, '0);
  endtask

  task automatic wr_a(string tag, logic c, logic [1:0] addr, logic [DW-1:0] d);
    cyc(tag, 1, 1, c, addr, d, 0, 0, 0, 2'd0, '0);
  endtask

  task automatic rd_b(string tag, logic c, logic [1:0] addr);
    cyc(tag, 0, 0, 0, 2'd0, '0, 1, 0, c, addr, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    idle("R1");
    cyc("R1", 1, 0, 0, 2'd2, '0, 1, 0, 1, 2'd2, '0);

    // R2 core0 -> core1 ordering, R11 read data same cycle
    wr_a("R2", 0, 2'd0, 32'hA000_0001);
    wr_a("R2", 0, 2'd0, 32'hA000_0002);
    rd_b("R2", 0, 2'd2);
    rd_b("R11", 1, 2'd1);
    rd_b("R11", 1, 2'd1);
    // R2 core1 -> core0 issued through port A with ID 1
    wr_a("R2", 1, 2'd0, 32'hB000_0011);
    rd_b("R2", 0, 2'd1);

    // R3/R4 fill core0 TX, then overflow
    for (int i = 0; i < DEPTH; i++) wr_a("R3", 0, 2'd0, 32'hC000_0000 + i);
    rd_b("R3", 0, 2'd2);
    wr_a("R4", 0, 2'd0, 32'hDEAD_BEEF);
    idle("R4");
    rd_b("R4", 0, 2'd2);
    // R3 full queue, same-cycle pop and push: push dropped
    cyc("R3", 1, 1, 0, 2'd0, 32'hFEED_0001, 1, 0, 1, 2'd1, '0);
    rd_b("R3", 0, 2'd2);

    // R6 clear flags with arbitrary data
    wr_a("R6", 0, 2'd2, 32'h1234_5678);
    rd_b("R6", 0, 2'd2);

    // R5 drain core1 RX, then underflow
    for (int i = 0; i < DEPTH - 1; i++) rd_b("R5", 1, 2'd1);
    rd_b("R5", 1, 2'd1);
    rd_b("R5", 1, 2'd2);
    wr_a("R5", 0, 2'd0, 32'h0000_5555);
    rd_b("R5", 1, 2'd1);
    wr_a("R6", 1, 2'd2, '0);

    // R8 both cores write in one cycle, then both read in one cycle
    cyc("R8", 1, 1, 0, 2'd0, 32'h0A0A_0A0A, 1, 1, 1, 2'd0, 32'h0B0B_0B0B);
    cyc("R8", 1, 0, 0, 2'd1, '0, 1, 0, 1, 2'd1, '0);
    cyc("R8", 1, 0, 1, 2'd2, '0, 1, 0, 0, 2'd2, '0);

    // R9 same ID on both ports: port B dropped
    cyc("R9", 1, 1, 0, 2'd0, 32'h9999_0001, 1, 1, 0, 2'd0, 32'h9999_0002);
    cyc("R9", 1, 0, 1, 2'd2, '0, 1, 0, 1, 2'd1, '0);
    rd_b("R9", 1, 2'd1);
    rd_b("R9", 1, 2'd2);

    // R10 unused offset and wrong directions
    wr_a("R10", 0, 2'd3, 32'h3333_3333);
    wr_a("R10", 0, 2'd1, 32'h1111_1111);
    rd_b("R10", 0, 2'd0);
    rd_b("R10", 0, 2'd3);
    rd_b("R10", 0, 2'd2);
    rd_b("R10", 1, 2'd2);
    idle("R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule